// File: doc/BRIEF.md
# Keyed Flash Control Register Unit

This unit sits on a simple processor register bus (address, write data, write strobe, combinational read data). It holds the settings that govern a flash interface: a 3-bit operating mode, an area-select field and a ROM-select bit. Software cannot change these settings directly. It first writes the new values into a staging register. They reach the flash interface only when the key byte 0xD5 is written to a separate commit register, so a single stray write cannot unlock program or erase sequences.

The unit drives three outputs to the flash side. The command enable lets the downstream decoder accept erase and write sequences. The other two are the area select and the ROM select. The command enable is high only while the committed mode is the run code 3'b101. The locked code 3'b010 is the reset value. It disables command sequences, as do all the other codes.

A normal session has two phases. To open, stage run mode with the target area, then write the key. To close, stage locked mode with area 00, then write the key again. This puts the mapping back in its initial state. The bus carries no handshake: every access completes in the cycle it is presented, so there is no back-pressure.

Top module: `flkey_ctrl`

## Requirements
- R1: After reset the committed mode is 3'b010, the area select is 2'b00, ROM select is 0 and the command enable is low, so the control register reads 0x02.
- R2: A write to the control register address (0x0) only loads the staging register. The outputs and the control register readback keep their committed values until a commit.
- R3: A write of 0xD5 to the commit register address (0x1) copies every staged field into the committed settings at that clock edge. The outputs show the new values from the following cycle.
- R4: A write of any other value to the commit register address changes neither the committed settings nor the outputs.
- R5: The command enable is high exactly when the committed mode is 3'b101.
- R6: The mode codes 3'b010, 3'b000 and 3'b111 (and every other code except 3'b101) hold the command enable low after commit.
- R7: Reading the control register address returns the committed fields, not the staged ones, laid out as mode in bits [2:0], area in bits [4:3] and ROM select in bit 5. All higher bits read 0, even when they were written as 1.
- R8: Reads of the commit register address and of unmapped addresses return 0. Writes to unmapped addresses affect no setting.
- R9: The staged values persist after a commit. A repeated key write with no new staging leaves the outputs unchanged, and new staging after a commit is applied by the next key write.
- R10: Committing the locked mode with area 2'b00 and ROM select 0 returns all outputs and the readback to their reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cmd_en | output | 1 | Command sequences accepted by the flash interface |
| area_sel | output | 2 | Committed flash area select |
| rom_sel | output | 1 | Committed ROM select |

## Verification
The bench builds the unit with its default parameters: an 8-bit data path, a 4-bit address, a 2-bit area field and the key 0xD5. With these values, every field, together with the zero padding above it, fits in one byte. The bench can therefore set each area code and the ROM bit and read them back, and it can also set the unused upper bits and confirm they are dropped. The 4-bit address leaves fourteen unmapped locations, and these are used to confirm that stray writes and reads have no effect.

// File: rtl/flkey_pkg.sv
package flkey_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_RUN  = 3'b101;
  localparam logic [MODE_W-1:0] MODE_LOCK = 3'b010;
endpackage

// File: rtl/flkey_busdec.sv
module flkey_busdec #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = '0,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 1,
  parameter logic [DATA_W-1:0] KEY         = 8'hD5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output logic              sel_ctrl,
  output logic              stage_we,
  output logic              key_hit
);
  logic sel_commit;
  always_comb begin
    sel_ctrl   = (addr == CTRL_ADDR);
    sel_commit = (addr == COMMIT_ADDR);
    stage_we   = wr && sel_ctrl;
    key_hit    = wr && sel_commit && (wdata == KEY);
  end
endmodule

// File: rtl/flkey_stage.sv
module flkey_stage
  import flkey_pkg::*;
#(
  parameter int AREA_W = 2,
  localparam int FIELD_W = MODE_W + AREA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FIELD_W-1:0] wfield,
  output logic [MODE_W-1:0] stg_mode,
  output logic [AREA_W-1:0] stg_area,
  output logic              stg_rom
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_mode <= MODE_LOCK;
      stg_area <= '0;
      stg_rom  <= 1'b0;
    end else if (we) begin
      stg_mode <= wfield[MODE_W-1:0];
      stg_area <= wfield[MODE_W +: AREA_W];
      stg_rom  <= wfield[FIELD_W-1];
    end
  end
endmodule

// File: rtl/flkey_active.sv
module flkey_active
  import flkey_pkg::*;
#(
  parameter int AREA_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [MODE_W-1:0] stg_mode,
  input  logic [AREA_W-1:0] stg_area,
  input  logic              stg_rom,
  output logic [MODE_W-1:0] act_mode,
  output logic [AREA_W-1:0] act_area,
  output logic              act_rom,
  output logic              act_run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= MODE_LOCK;
      act_area <= '0;
      act_rom  <= 1'b0;
      act_run  <= 1'b0;
    end else if (commit) begin
      act_mode <= stg_mode;
      act_area <= stg_area;
      act_rom  <= stg_rom;
      act_run  <= (stg_mode == MODE_RUN);
    end
  end
endmodule

// File: rtl/flkey_rdmux.sv
module flkey_rdmux
  import flkey_pkg::*;
#(
  parameter int AREA_W = 2,
  parameter int DATA_W = 8,
  localparam int FIELD_W = MODE_W + AREA_W + 1
) (
  input  logic              sel_ctrl,
  input  logic [MODE_W-1:0] act_mode,
  input  logic [AREA_W-1:0] act_area,
  input  logic              act_rom,
  output logic [DATA_W-1:0] rdata
);
  logic [FIELD_W-1:0] word;
  always_comb begin
    word  = {act_rom, act_area, act_mode};
    rdata = sel_ctrl ? DATA_W'(word) : '0;
  end
endmodule

// File: rtl/flkey_ctrl.sv
module flkey_ctrl
  import flkey_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int AREA_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = '0,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 1,
  parameter logic [DATA_W-1:0] KEY         = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cmd_en,
  output logic [AREA_W-1:0] area_sel,
  output logic              rom_sel
);
  localparam int FIELD_W = MODE_W + AREA_W + 1;

  logic              sel_ctrl, stage_we, key_hit;
  logic [MODE_W-1:0] stg_mode, act_mode;
  logic [AREA_W-1:0] stg_area, act_area;
  logic              stg_rom, act_rom, act_run;

  flkey_busdec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .COMMIT_ADDR(COMMIT_ADDR), .KEY(KEY)
  ) u_dec (
    .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr),
    .sel_ctrl(sel_ctrl), .stage_we(stage_we), .key_hit(key_hit)
  );

  flkey_stage #(.AREA_W(AREA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .we(stage_we),
    .wfield(bus_wdata[FIELD_W-1:0]),
    .stg_mode(stg_mode), .stg_area(stg_area), .stg_rom(stg_rom)
  );

  flkey_active #(.AREA_W(AREA_W)) u_act (
    .clk(clk), .rst_n(rst_n), .commit(key_hit),
    .stg_mode(stg_mode), .stg_area(stg_area), .stg_rom(stg_rom),
    .act_mode(act_mode), .act_area(act_area), .act_rom(act_rom),
    .act_run(act_run)
  );

  flkey_rdmux #(.AREA_W(AREA_W), .DATA_W(DATA_W)) u_rd (
    .sel_ctrl(sel_ctrl), .act_mode(act_mode), .act_area(act_area),
    .act_rom(act_rom), .rdata(bus_rdata)
  );

  assign cmd_en   = act_run;
  assign area_sel = act_area;
  assign rom_sel  = act_rom;
endmodule

// File: rtl/flkey_ctrl_chk.sv
module flkey_ctrl_chk
  import flkey_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int AREA_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = '0,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 1,
  parameter logic [DATA_W-1:0] KEY         = 8'hD5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cmd_en,
  input logic [AREA_W-1:0] area_sel,
  input logic              rom_sel,
  input logic [MODE_W-1:0] stg_mode,
  input logic [AREA_W-1:0] stg_area,
  input logic              stg_rom
);
  logic keyed;
  assign keyed = bus_wr && (bus_addr == COMMIT_ADDR) && (bus_wdata == KEY);

  assert_hold_unkeyed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !keyed |=> ($stable(cmd_en) && $stable(area_sel) && $stable(rom_sel)));

  assert_commit_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    keyed |=> (area_sel == $past(stg_area) && rom_sel == $past(stg_rom)
               && cmd_en == ($past(stg_mode) == MODE_RUN)));

  assert_enable_tracks_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_ADDR) |-> (cmd_en == (bus_rdata[MODE_W-1:0] == MODE_RUN)));

  assert_commit_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == COMMIT_ADDR) |-> (bus_rdata == '0));

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cmd_en && area_sel == '0 && !rom_sel));
endmodule

bind flkey_ctrl flkey_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AREA_W(AREA_W),
  .CTRL_ADDR(CTRL_ADDR), .COMMIT_ADDR(COMMIT_ADDR), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .cmd_en(cmd_en),
  .area_sel(area_sel), .rom_sel(rom_sel),
  .stg_mode(stg_mode), .stg_area(stg_area), .stg_rom(stg_rom)
);

// File: tb/flkey_ctrl_tb.sv
module flkey_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       cmd_en;
  logic [1:0] area_sel;
  logic       rom_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_KEY  = 4'h1;

  always #5 clk = ~clk;

  flkey_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .cmd_en(cmd_en),
    .area_sel(area_sel), .rom_sel(rom_sel)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_CTRL;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // expected outputs for a committed control word
  task automatic expect_state(string req, logic [7:0] word);
    logic [7:0] r;
    rd(A_CTRL, r);
    check(req, r, word & 8'h3F);
    check(req, cmd_en, word[2:0] == 3'b101);
    check(req, area_sel, word[4:3]);
    check(req, rom_sel, word[5]);
  endtask

  task automatic t_reset;
    expect_state("R1", 8'h02);
  endtask

  task automatic t_stage_only;
    wr(A_CTRL, 8'h3D);
    expect_state("R2", 8'h02);
  endtask

  task automatic t_wrong_key;
    wr(A_KEY, 8'hD4);
    expect_state("R4", 8'h02);
    wr(A_KEY, 8'h00);
    wr(A_KEY, 8'h55);
    expect_state("R4", 8'h02);
  endtask

  task automatic t_good_key;
    wr(A_KEY, 8'hD5);
    expect_state("R3", 8'h3D);
    check("R5", cmd_en, 1);
  endtask

  task automatic t_layout;
    wr(A_CTRL, 8'hCD);           // mode 101, area 01, rom 0, upper bits set
    wr(A_KEY, 8'hD5);
    expect_state("R7", 8'h0D);
    wr(A_CTRL, 8'h22);           // stage only: readback must stay committed
    expect_state("R7", 8'h0D);
  endtask

  task automatic t_other_modes;
    wr(A_KEY, 8'hD5);            // commits 0x22: mode 010, rom 1
    expect_state("R6", 8'h22);
    check("R6", cmd_en, 0);
    wr(A_CTRL, 8'h10);           // mode 000, area 10
    wr(A_KEY, 8'hD5);
    expect_state("R6", 8'h10);
    wr(A_CTRL, 8'h0F);           // mode 111, area 01
    wr(A_KEY, 8'hD5);
    expect_state("R6", 8'h0F);
    check("R6", cmd_en, 0);
  endtask

  task automatic t_unmapped;
    logic [7:0] r;
    for (int a = 2; a < 16; a++) wr(4'(a), 8'hD5);
    expect_state("R8", 8'h0F);
    rd(A_KEY, r);
    check("R8", r, 0);
    rd(4'h7, r);
    check("R8", r, 0);
  endtask

  task automatic t_recommit;
    wr(A_KEY, 8'hD5);            // staged still 0x0F
    expect_state("R9", 8'h0F);
    wr(A_CTRL, 8'h2D);
    wr(A_KEY, 8'hD5);
    expect_state("R9", 8'h2D);
  endtask

  task automatic t_restore;
    wr(A_CTRL, 8'h02);
    wr(A_KEY, 8'hD5);
    expect_state("R10", 8'h02);
  endtask

  task automatic t_midreset;
    wr(A_CTRL, 8'h1D);
    wr(A_KEY, 8'hD5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_state("R1", 8'h02);
    wr(A_KEY, 8'hD5);            // staging also reset: commit gives reset word
    expect_state("R1", 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stage_only();
    t_wrong_key();
    t_good_key();
    t_layout();
    t_other_modes();
    t_unmapped();
    t_recommit();
    t_restore();
    t_midreset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule